// File: doc/BRIEF.md
# Six-Pin Bidirectional GPIO Port

This block is a small general-purpose I/O port of six pins, each of which can be used as an input or as an output. Software reaches it through a simple synchronous register bus. The block keeps a direction register, an output data latch, an analog-select register, a per-pin pull-up enable register, a per-pin input-threshold select register and a control register. The control register holds a global pull-up disable bit. For every pin it produces an output value, an output enable, a pull-up enable and a threshold select. It also accepts a pad input that is already resolved to a logic level.

Reads of the port register return the pad levels after a two-flop synchronizer. Pins that are analog-selected are masked to zero. Writes to the port register load the output latch. The latch also has an address of its own, so software can read back the value stored there. Pin 3 is input-only: its driver is never enabled, and its direction bit always reads as 1. Analog selection changes only what a digital read returns. An analog-selected pin whose direction bit is 0 still drives its latch value.

The bus read path is combinational from the address. A write takes effect at the clock edge on which `bus_we` is sampled high. The register addresses are: 0 port, 1 latch, 2 direction, 3 analog select, 4 pull-up enable, 5 threshold select, 6 control. Bit 0 of the control register is the global pull-up disable, and address 7 reads as zero. In every register, pin n maps to bit n.

Top module: `gpio6_port`

## Requirements
- R1: Direction bit 1 makes a pin an input, so `pad_oe` is 0. Direction bit 0 sets `pad_oe` to 1 and places the latch bit on `pad_out`. Direction reads back at address 2.
- R2: Pin 3 is input-only. `pad_oe[3]` is always 0, and bit 3 of the direction register reads 1 whatever is written to it.
- R3: A write to address 0 (port) loads the output latch with `bus_wdata[5:0]`. A write to address 1 loads it as well. Address 1 reads back the stored latch value.
- R4: A read of address 0 returns the pad levels through a two-flop synchronizer. A pad change becomes visible after two rising clock edges.
- R5: A 1 in the analog-select register (address 3) makes that pin read 0 at address 0. It does not change `pad_oe` or `pad_out`.
- R6: `pad_pu[n]` is 1 only when all three hold: the pull-up enable bit n (address 4) is 1, pin n is an input, and the global disable bit is 0.
- R7: The global pull-up disable bit is control bit 0 (address 6). It is 1 after reset, and while it is 1 every `pad_pu` bit is 0.
- R8: The threshold select register (address 5) is stored, read back and driven unchanged on `pad_thr`.
- R9: Bits 7:6 of every register read as 0, and writes to them are ignored. Address 7 reads 0.
- R10: After reset the direction bits are all 1, the analog-select bits are all 1, and the latch, the pull-up enables and the threshold selects are all 0.
- R11: Consider an output pin that is also analog-selected. A read-modify-write of the port register (read address 0, write the value back) clears that pin's latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pad_in | input | 6 | Resolved pad input levels |
| pad_out | output | 6 | Output values to pads |
| pad_oe | output | 6 | Output driver enables |
| pad_pu | output | 6 | Effective weak pull-up enables |
| pad_thr | output | 6 | Input threshold select per pin |

## Verification
The hardest case to reach is a pin that is driving and analog-selected at the same time. In that case the digital read path disagrees with the driven value, and a read-modify-write silently clears the latch bit. To reach it, the bench enables every output and loads the latch with all ones. It loops the driven value back onto the pad inputs, sets a single analog bit, waits out the synchronizer and then writes back the value it read. Two sweeps run over all 64 codes: one covers direction against pull-up enable, and the other covers pad input against several analog masks. Both sweeps include the forced input-only pin.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT  = 3'd0,
    REG_LATCH = 3'd1,
    REG_DIR   = 3'd2,
    REG_ANA   = 3'd3,
    REG_PUEN  = 3'd4,
    REG_THR   = 3'd5,
    REG_CTRL  = 3'd6
  } gpio_reg_e;

  // effective pull-up: enabled, pin is input, global disable clear
  function automatic logic pull_on(input logic dir_in, input logic en, input logic gdis);
    return dir_in & en & ~gdis;
  endfunction

  // digital read value: analog pins read zero
  function automatic logic read_bit(input logic sync_lvl, input logic ana);
    return sync_lvl & ~ana;
  endfunction
endpackage

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio6_regs.sv
module gpio6_regs
  import gpio6_pkg::*;
#(
  parameter int W       = 6,
  parameter int IN_ONLY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BUS_W-1:0]  wdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      ana_q,
  output logic [W-1:0]      puen_q,
  output logic [W-1:0]      thr_q,
  output logic              gdis_q
);
  localparam logic [W-1:0] IN_MASK = W'(1) << IN_ONLY;

  logic [W-1:0] wpins;
  logic         unused_wdata;
  logic         wr_latch, wr_dir, wr_ana, wr_puen, wr_thr, wr_ctrl;

  assign wpins        = wdata[W-1:0];
  assign unused_wdata = ^wdata[BUS_W-1:W];

  // write events brought out as named wires
  assign wr_latch = we && (addr == REG_PORT || addr == REG_LATCH);
  assign wr_dir   = we && addr == REG_DIR;
  assign wr_ana   = we && addr == REG_ANA;
  assign wr_puen  = we && addr == REG_PUEN;
  assign wr_thr   = we && addr == REG_THR;
  assign wr_ctrl  = we && addr == REG_CTRL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '1;
      latch_q <= '0;
      ana_q   <= '1;
      puen_q  <= '0;
      thr_q   <= '0;
      gdis_q  <= 1'b1;
    end else begin
      if (wr_latch) latch_q <= wpins;
      if (wr_dir)   dir_q   <= wpins | IN_MASK;
      if (wr_ana)   ana_q   <= wpins;
      if (wr_puen)  puen_q  <= wpins;
      if (wr_thr)   thr_q   <= wpins;
      if (wr_ctrl)  gdis_q  <= wdata[0];
    end
  end
endmodule

// File: rtl/gpio6_pin_ctrl.sv
module gpio6_pin_ctrl
  import gpio6_pkg::*;
#(
  parameter int W       = 6,
  parameter int IN_ONLY = 3
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] puen_q,
  input  logic [W-1:0] sync_q,
  input  logic [W-1:0] ana_q,
  input  logic         gdis_q,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu,
  output logic [W-1:0] pin_rd
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      if (i == IN_ONLY) begin : g_inonly
        assign pin_oe[i]  = 1'b0;
        assign pin_out[i] = 1'b0;
        assign pin_pu[i]  = pull_on(1'b1, puen_q[i], gdis_q);
      end else begin : g_bidir
        assign pin_oe[i]  = ~dir_q[i];
        assign pin_out[i] = latch_q[i];
        assign pin_pu[i]  = pull_on(dir_q[i], puen_q[i], gdis_q);
      end
      assign pin_rd[i] = read_bit(sync_q[i], ana_q[i]);
    end
  endgenerate
endmodule

// File: rtl/gpio6_rdmux.sv
module gpio6_rdmux
  import gpio6_pkg::*;
#(
  parameter int W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      pin_rd,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      latch_q,
  input  logic [W-1:0]      ana_q,
  input  logic [W-1:0]      puen_q,
  input  logic [W-1:0]      thr_q,
  input  logic              gdis_q,
  output logic [BUS_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    case (addr)
      REG_PORT:  rdata[W-1:0] = pin_rd;
      REG_LATCH: rdata[W-1:0] = latch_q;
      REG_DIR:   rdata[W-1:0] = dir_q;
      REG_ANA:   rdata[W-1:0] = ana_q;
      REG_PUEN:  rdata[W-1:0] = puen_q;
      REG_THR:   rdata[W-1:0] = thr_q;
      REG_CTRL:  rdata[0]     = gdis_q;
      default:   rdata        = '0;
    endcase
  end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
  import gpio6_pkg::*;
#(
  parameter int WIDTH          = 6,
  parameter int INPUT_ONLY_PIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pu,
  output logic [WIDTH-1:0]  pad_thr
);
  logic [WIDTH-1:0] dir_q, latch_q, ana_q, puen_q, thr_q, sync_q, pin_rd;
  logic             gdis_q;
  logic             pu_global_off;

  assign pu_global_off = gdis_q;

  gpio6_regs #(.W(WIDTH), .IN_ONLY(INPUT_ONLY_PIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .dir_q(dir_q), .latch_q(latch_q), .ana_q(ana_q), .puen_q(puen_q),
    .thr_q(thr_q), .gdis_q(gdis_q)
  );

  gpio6_sync #(.W(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
  );

  gpio6_pin_ctrl #(.W(WIDTH), .IN_ONLY(INPUT_ONLY_PIN)) u_pins (
    .dir_q(dir_q), .latch_q(latch_q), .puen_q(puen_q), .sync_q(sync_q),
    .ana_q(ana_q), .gdis_q(gdis_q), .pin_out(pad_out), .pin_oe(pad_oe),
    .pin_pu(pad_pu), .pin_rd(pin_rd)
  );

  gpio6_rdmux #(.W(WIDTH)) u_rd (
    .addr(bus_addr), .pin_rd(pin_rd), .dir_q(dir_q), .latch_q(latch_q),
    .ana_q(ana_q), .puen_q(puen_q), .thr_q(thr_q), .gdis_q(gdis_q),
    .rdata(bus_rdata)
  );

  assign pad_thr = thr_q;
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk
  import gpio6_pkg::*;
#(
  parameter int W       = 6,
  parameter int IN_ONLY = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_pu,
  input logic [W-1:0]      latch_q,
  input logic [W-1:0]      ana_q,
  input logic              pu_global_off
);
  // R2
  inonly_never_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe[IN_ONLY]);

  // R2
  inonly_dir_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_DIR) |-> bus_rdata[IN_ONLY]);

  // R3
  port_write_loads_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_PORT) |=> (latch_q == $past(bus_wdata[W-1:0])));

  // R5
  analog_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_PORT) |-> ((bus_rdata[W-1:0] & ana_q) == '0));

  // R6
  no_pullup_when_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  // R7
  global_pullup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pu_global_off |-> (pad_pu == '0));

  // R9
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_W-1:W] == '0);
endmodule

bind gpio6_port gpio6_port_chk #(.W(WIDTH), .IN_ONLY(INPUT_ONLY_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .latch_q(latch_q), .ana_q(ana_q),
  .pu_global_off(pu_global_off)
);

// File: tb/gpio6_port_test.sv
module gpio6_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pad_in = '0;
  logic [5:0] pad_out, pad_oe, pad_pu, pad_thr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio6_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_thr(pad_thr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle_pads(input logic [5:0] v);
    @(negedge clk);
    pad_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] r;
    logic [5:0] dir_e, pen, ana;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(3'd2, r); chk("R10 dir", r, 8'h3F);
    rd(3'd3, r); chk("R10 analog", r, 8'h3F);
    rd(3'd1, r); chk("R10 latch", r, 8'h00);
    rd(3'd4, r); chk("R10 pull-up enable", r, 8'h00);
    rd(3'd5, r); chk("R10 threshold", r, 8'h00);
    chk("R10 pad_oe", {2'b0, pad_oe}, 8'h00);
    // R7 global disable set at reset
    rd(3'd6, r); chk("R7 ctrl reset", r, 8'h01);
    wr(3'd4, 8'h3F);
    chk("R7 pulls off while disabled", {2'b0, pad_pu}, 8'h00);
    wr(3'd6, 8'h00);

    // R1 R2 R6 sweep direction against pull-up enable
    for (int d = 0; d < 64; d++) begin
      pen = 6'(d) ^ 6'h2A;
      wr(3'd1, 8'(d) ^ 8'h15);
      wr(3'd4, 8'(pen));
      wr(3'd2, 8'(d));
      dir_e = 6'(d) | 6'h08;
      rd(3'd2, r); chk("R2 dir readback", r, {2'b0, dir_e});
      chk("R1 pad_oe", {2'b0, pad_oe}, {2'b0, ~dir_e});
      chk("R1 pad_out on driven pins", {2'b0, pad_out & pad_oe},
          {2'b0, (6'(d) ^ 6'h15) & ~dir_e});
      chk("R6 pad_pu", {2'b0, pad_pu}, {2'b0, pen & dir_e});
    end

    // R7 global disable overrides
    wr(3'd2, 8'h3F); wr(3'd4, 8'h3F);
    chk("R6 all inputs pulled", {2'b0, pad_pu}, 8'h3F);
    wr(3'd6, 8'h01);
    chk("R7 global disable", {2'b0, pad_pu}, 8'h00);

    // R4 R5 sweep pad input against analog masks
    for (int m = 0; m < 4; m++) begin
      ana = (m == 0) ? 6'h00 : (m == 1) ? 6'h3F : (m == 2) ? 6'h15 : 6'h2A;
      wr(3'd3, 8'(ana));
      for (int v = 0; v < 64; v++) begin
        settle_pads(6'(v));
        rd(3'd0, r);
        chk("R4 R5 port read", r, {2'b0, 6'(v) & ~ana});
      end
    end

    // R4 two-edge latency: one edge is not enough
    wr(3'd3, 8'h00);
    settle_pads(6'h00);
    @(negedge clk); pad_in = 6'h3F;
    @(negedge clk);
    rd(3'd0, r); chk("R4 one edge", r, 8'h00);
    @(negedge clk);
    rd(3'd0, r); chk("R4 two edges", r, 8'h3F);

    // R3 port write loads latch, latch address too
    wr(3'd0, 8'hE9); rd(3'd1, r); chk("R3 port write", r, 8'h29);
    wr(3'd1, 8'h16); rd(3'd1, r); chk("R3 latch write", r, 8'h16);

    // R8 threshold pass-through
    wr(3'd5, 8'hDB); rd(3'd5, r); chk("R8 thr readback", r, 8'h1B);
    chk("R8 pad_thr", {2'b0, pad_thr}, 8'h1B);

    // R9 upper bits and unused address
    wr(3'd3, 8'hC0); rd(3'd3, r); chk("R9 analog upper", r, 8'h00);
    rd(3'd7, r); chk("R9 addr 7", r, 8'h00);
    wr(3'd6, 8'hFE); rd(3'd6, r); chk("R9 ctrl upper", r, 8'h00);

    // R5 analog does not disturb driving; R11 read-modify-write
    wr(3'd2, 8'h00); wr(3'd1, 8'h3F); wr(3'd3, 8'h01);
    chk("R5 analog pin still drives", {2'b0, pad_out & pad_oe}, 8'h37);
    settle_pads(6'h3F);
    rd(3'd0, r); chk("R11 read masks analog pin", r, 8'h3E);
    wr(3'd0, r);
    rd(3'd1, r); chk("R11 latch bit cleared", r, 8'h3E);

    finish_up();
  end
endmodule